// File: doc/BRIEF.md
# Frame capture and crop controller

This block decides which pixels of an incoming video stream are kept. It watches a vertical and a horizontal blanking signal (both already corrected so that 1 means "sync active") and a per-pixel valid strobe. From these it tracks frame and line boundaries and produces a qualified pixel-valid output plus end-of-line and end-of-frame pulses. A downstream packer uses these outputs to assemble words.

Software arms capture with a set pulse and may disarm it with a clear pulse. In single-frame mode the block disarms itself after one frame and raises a sticky frame-done flag. In continuous mode it keeps capturing and can keep only one frame in two or one in four. It can keep only every other line. It can also restrict capture to a rectangular window given by a first line, a pixel offset, a line count and a pixel count.

Top module: `cap_frame_ctrl`

## Requirements
- R1: After capture_on rises, no pixel is accepted until the next frame start, which is a falling edge of vsync_act. Pixels of a frame already in progress are dropped.
- R2: With snapshot_mode=1, the block accepts exactly one frame. At the end of that frame capture_on returns to 0 in the same cycle that frame_end pulses, and later frames are not accepted.
- R3: With snapshot_mode=0, a cap_clr pulse during an accepted frame lowers capture_on at once. Pixels keep being accepted until that frame ends, and no frame after it is taken.
- R4: In continuous mode rate_code selects which frames are kept, counting from the first frame start after arming. 2'b00 keeps every frame, 2'b01 keeps frames 0, 2, 4 and so on, and 2'b10 keeps frames 0, 4, 8 and so on. 2'b11 behaves like 2'b00.
- R5: With line_sel_en=1, only lines whose index from frame start (0-based) has bit 0 equal to line_sel_odd are accepted. line_sel_odd=0 keeps lines 0, 2, 4 and so on; line_sel_odd=1 keeps lines 1, 3, 5 and so on.
- R6: With crop_en=1, line L is accepted if crop_vstart <= L <= crop_vstart + crop_vlines. Within such a line, pixel P (0-based, counted on valid pixels while hsync_act=0) is accepted if crop_hoff <= P <= crop_hoff + C, where C is crop_hcount with bits [1:0] cleared.
- R7: Bits [1:0] of crop_hcount have no effect on which pixels are accepted.
- R8: With crop_en=1, the hsync_act rising edge that ends line crop_vstart + crop_vlines completes the frame. frame_end pulses and frame_done sets one cycle later, and the rest of that frame is not accepted.
- R9: A crop window that reaches past the line or the frame is cut at the real line end or frame end. The frame then completes on the rising edge of vsync_act, with frame_end and frame_done.
- R10: A pixel strobe is never accepted while hsync_act or vsync_act is 1.
- R11: pix_out_vld, line_end and frame_end are registered, one cycle after the input cycle that causes them. line_end pulses once for each line of an accepted frame that passes the vertical window and line selection. frame_end pulses once per accepted frame.
- R12: Under reset, pix_out_vld, line_end, frame_end, capture_on and frame_done are all 0.
- R13: frame_done is set whenever frame_end pulses and stays 1 until a done_clr pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync_act | input | 1 | Vertical sync, 1 = active (blanking) |
| hsync_act | input | 1 | Horizontal sync, 1 = active (blanking) |
| pix_vld | input | 1 | One pixel present this cycle |
| cap_set | input | 1 | Pulse: arm capture |
| cap_clr | input | 1 | Pulse: disarm capture |
| snapshot_mode | input | 1 | 1 = single frame, 0 = continuous |
| rate_code | input | 2 | Frame keep rate in continuous mode |
| line_sel_en | input | 1 | Keep one line in two |
| line_sel_odd | input | 1 | Parity of kept lines |
| crop_en | input | 1 | Enable crop window |
| crop_vstart | input | 13 | First window line |
| crop_vlines | input | 14 | Window height minus one |
| crop_hoff | input | 14 | First window pixel in a line |
| crop_hcount | input | 14 | Window width minus one, bits [1:0] ignored |
| done_clr | input | 1 | Pulse: clear frame_done |
| pix_out_vld | output | 1 | Accepted pixel |
| line_end | output | 1 | Pulse at end of an accepted line |
| frame_end | output | 1 | Pulse at end of an accepted frame |
| capture_on | output | 1 | Capture armed |
| frame_done | output | 1 | Sticky frame-complete flag |

## Verification
If the line or pixel counters drift, the window shifts, and this shows up in the same frame: in the count of accepted pixels, in the line and pixel index of the first accepted pixel, and in the line on which frame_end fires. A wrong frame-skip count or sequencer state shows within one to five frames, as a wrong number of frame_end pulses. A missed auto-clear of capture_on shows on the very next frame, which then delivers pixels it should not.

// File: rtl/cap_frame_pkg.sv
// Shared types for the frame capture controller.
package cap_frame_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARM   = 2'd1,
        SEQ_FRAME = 2'd2
    } seq_state_t;

    localparam int SKIP_W = 2;

    // Mask applied to the frame-skip counter; zero result keeps the frame.
    function automatic logic [SKIP_W-1:0] rate_mask(input logic [1:0] code);
        case (code)
            2'b01:   rate_mask = 2'b01;
            2'b10:   rate_mask = 2'b11;
            default: rate_mask = 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/cap_edge_track.sv
// Registers N level signals and reports rising/falling edges per bit.
// Assumes inputs are already synchronous to clk. Previous value resets to 0,
// so a signal held low through reset produces no edge.
module cap_edge_track #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] lvl_q;

    // Hold previous level of each tracked signal.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise[i] = lvl[i] & ~lvl_q[i];
        assign fall[i] = ~lvl[i] & lvl_q[i];
    end
endmodule

// File: rtl/cap_frame_seq.sv
// Frame sequencer: arming, frame-start wait, frame decimation, snapshot
// auto-stop, deferred stop and the sticky done flag.
// Assumes vs_fall/vs_rise are single-cycle edge strobes of the vertical sync.
module cap_frame_seq
    import cap_frame_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_set,
    input  logic       cap_clr,
    input  logic       snapshot,
    input  logic [1:0] rate_code,
    input  logic       vs_fall,
    input  logic       vs_rise,
    input  logic       win_done,
    input  logic       done_clr,
    output logic       capture_on,
    output logic       frame_active,
    output logic       frame_start,
    output logic       frame_end,
    output logic       frame_done
);
    seq_state_t        state;
    logic [SKIP_W-1:0] skip_cnt;
    logic              take;
    logic              finish;

    // Decide whether the upcoming frame is kept and whether the current ends.
    always_comb begin
        take        = snapshot || ((skip_cnt & rate_mask(rate_code)) == '0);
        frame_start = (state == SEQ_ARM) && capture_on && vs_fall && take;
        finish      = (state == SEQ_FRAME) && (vs_rise || win_done);
    end

    assign frame_active = (state == SEQ_FRAME);

    // Sequencer state and frame-skip counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            skip_cnt <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    skip_cnt <= '0;
                    if (capture_on) state <= SEQ_ARM;
                end
                SEQ_ARM: begin
                    if (!capture_on) begin
                        state <= SEQ_IDLE;
                    end else if (vs_fall) begin
                        skip_cnt <= skip_cnt + 1'b1;
                        if (take) state <= SEQ_FRAME;
                    end
                end
                SEQ_FRAME: begin
                    if (finish)
                        state <= (snapshot || !capture_on) ? SEQ_IDLE : SEQ_ARM;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Capture enable: software set/clear with snapshot auto-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                   capture_on <= 1'b0;
        else if (cap_set)             capture_on <= 1'b1;
        else if (cap_clr)             capture_on <= 1'b0;
        else if (finish && snapshot)  capture_on <= 1'b0;
    end

    // End-of-frame pulse and sticky done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_end  <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_end <= finish;
            if (finish)        frame_done <= 1'b1;
            else if (done_clr) frame_done <= 1'b0;
        end
    end
endmodule

// File: rtl/cap_window.sv
// Line/pixel position counters with crop window and line-parity selection.
// Assumes hsync is active between lines; the pixel index restarts while
// hsync is active and at frame start.
module cap_window #(
    parameter int LINE_W = 14,
    parameter int PIX_W  = 14,
    parameter int VST_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_active,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              hs_rise,
    input  logic              pix_vld,
    input  logic              crop_en,
    input  logic              ls_en,
    input  logic              ls_odd,
    input  logic [VST_W-1:0]  vstart,
    input  logic [LINE_W-1:0] vlines,
    input  logic [PIX_W-1:0]  hoff,
    input  logic [PIX_W-1:0]  hcount,
    output logic              pix_out_vld,
    output logic              line_end,
    output logic              win_done
);
    localparam int LCW = LINE_W + 1;
    localparam int PCW = PIX_W + 1;

    logic [LCW-1:0]   line_idx;
    logic [PCW-1:0]   pix_idx;
    logic [LCW-1:0]   v_off;
    logic [PCW-1:0]   h_off;
    logic [PIX_W-1:0] h_cnt_eff;
    logic             data_ok, line_in_v, parity_ok, pix_in_h, v_reached;

    // Window and selection decode from current position.
    always_comb begin
        data_ok   = pix_vld && !hsync && !vsync;
        v_off     = line_idx - LCW'(vstart);
        v_reached = line_idx >= LCW'(vstart);
        line_in_v = !crop_en || (v_reached && v_off <= LCW'(vlines));
        parity_ok = !ls_en || (line_idx[0] == ls_odd);
        h_cnt_eff = hcount & ~PIX_W'(3);
        h_off     = pix_idx - PCW'(hoff);
        pix_in_h  = !crop_en || (pix_idx >= PCW'(hoff) && h_off <= PCW'(h_cnt_eff));
        win_done  = crop_en && frame_active && hs_rise && v_reached
                    && v_off == LCW'(vlines);
    end

    // Line index within the frame, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                       line_idx <= '0;
        else if (frame_start)             line_idx <= '0;
        else if (frame_active && hs_rise && line_idx != '1)
                                          line_idx <= line_idx + 1'b1;
    end

    // Pixel index within the line, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                       pix_idx <= '0;
        else if (frame_start || hsync)    pix_idx <= '0;
        else if (frame_active && data_ok && pix_idx != '1)
                                          pix_idx <= pix_idx + 1'b1;
    end

    // Registered qualified pixel and line-end strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out_vld <= 1'b0;
            line_end    <= 1'b0;
        end else begin
            pix_out_vld <= frame_active && data_ok && line_in_v && parity_ok && pix_in_h;
            line_end    <= frame_active && hs_rise && line_in_v && parity_ok;
        end
    end
endmodule

// File: rtl/cap_frame_ctrl.sv
// Top of the frame capture controller. Takes polarity-corrected sync levels
// (1 = active) and a pixel strobe, all synchronous to clk.
module cap_frame_ctrl #(
    parameter int LINE_W = 14,
    parameter int PIX_W  = 14,
    parameter int VST_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_act,
    input  logic              hsync_act,
    input  logic              pix_vld,
    input  logic              cap_set,
    input  logic              cap_clr,
    input  logic              snapshot_mode,
    input  logic [1:0]        rate_code,
    input  logic              line_sel_en,
    input  logic              line_sel_odd,
    input  logic              crop_en,
    input  logic [VST_W-1:0]  crop_vstart,
    input  logic [LINE_W-1:0] crop_vlines,
    input  logic [PIX_W-1:0]  crop_hoff,
    input  logic [PIX_W-1:0]  crop_hcount,
    input  logic              done_clr,
    output logic              pix_out_vld,
    output logic              line_end,
    output logic              frame_end,
    output logic              capture_on,
    output logic              frame_done
);
    logic [1:0] rise, fall;
    logic       frame_active, frame_start, win_done;

    cap_edge_track #(.N(2)) u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({hsync_act, vsync_act}),
        .rise (rise),
        .fall (fall)
    );

    cap_frame_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_set     (cap_set),
        .cap_clr     (cap_clr),
        .snapshot    (snapshot_mode),
        .rate_code   (rate_code),
        .vs_fall     (fall[0]),
        .vs_rise     (rise[0]),
        .win_done    (win_done),
        .done_clr    (done_clr),
        .capture_on  (capture_on),
        .frame_active(frame_active),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .frame_done  (frame_done)
    );

    cap_window #(.LINE_W(LINE_W), .PIX_W(PIX_W), .VST_W(VST_W)) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_active(frame_active),
        .hsync       (hsync_act),
        .vsync       (vsync_act),
        .hs_rise     (rise[1]),
        .pix_vld     (pix_vld),
        .crop_en     (crop_en),
        .ls_en       (line_sel_en),
        .ls_odd      (line_sel_odd),
        .vstart      (crop_vstart),
        .vlines      (crop_vlines),
        .hoff        (crop_hoff),
        .hcount      (crop_hcount),
        .pix_out_vld (pix_out_vld),
        .line_end    (line_end),
        .win_done    (win_done)
    );

    // fall[1] (line start) is not needed; tie it into nothing observable.
    logic unused_hs_fall;
    assign unused_hs_fall = fall[1];
endmodule

// File: rtl/cap_frame_ctrl_chk.sv
// Property checker for cap_frame_ctrl, attached with bind.
module cap_frame_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic vsync_act,
    input logic hsync_act,
    input logic pix_vld,
    input logic cap_set,
    input logic snapshot_mode,
    input logic done_clr,
    input logic pix_out_vld,
    input logic line_end,
    input logic frame_end,
    input logic capture_on,
    input logic frame_done
);
    // R10: an accepted pixel always came from a strobe outside sync.
    a_r10_sync_blocks_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        pix_out_vld |-> $past(pix_vld && !hsync_act && !vsync_act));

    // R11: frame_end and line_end are single-cycle pulses.
    a_r11_frame_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);
    a_r11_line_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> !line_end);

    // R2: snapshot completion drops capture_on with frame_end.
    a_r2_snapshot_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && $past(snapshot_mode) && !$past(cap_set)) |-> !capture_on);

    // R13: done flag holds until cleared.
    a_r13_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frame_done) && !$past(done_clr)) |-> frame_done);

    // R13: done flag only rises together with frame_end.
    a_r13_done_with_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_done) |-> frame_end);
endmodule

bind cap_frame_ctrl cap_frame_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vsync_act    (vsync_act),
    .hsync_act    (hsync_act),
    .pix_vld      (pix_vld),
    .cap_set      (cap_set),
    .snapshot_mode(snapshot_mode),
    .done_clr     (done_clr),
    .pix_out_vld  (pix_out_vld),
    .line_end     (line_end),
    .frame_end    (frame_end),
    .capture_on   (capture_on),
    .frame_done   (frame_done)
);

// File: tb/cap_frame_ctrl_tb_top.sv
module cap_frame_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vsync_act = 1'b1, hsync_act = 1'b1, pix_vld = 1'b0;
    logic cap_set = 1'b0, cap_clr = 1'b0, snapshot_mode = 1'b1, done_clr = 1'b0;
    logic [1:0] rate_code = 2'b00;
    logic line_sel_en = 1'b0, line_sel_odd = 1'b0, crop_en = 1'b0;
    logic [12:0] crop_vstart = '0;
    logic [13:0] crop_vlines = '0, crop_hoff = '0, crop_hcount = '0;
    logic pix_out_vld, line_end, frame_end, capture_on, frame_done;

    always #4 clk = ~clk;

    cap_frame_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .vsync_act(vsync_act), .hsync_act(hsync_act),
        .pix_vld(pix_vld), .cap_set(cap_set), .cap_clr(cap_clr),
        .snapshot_mode(snapshot_mode), .rate_code(rate_code),
        .line_sel_en(line_sel_en), .line_sel_odd(line_sel_odd), .crop_en(crop_en),
        .crop_vstart(crop_vstart), .crop_vlines(crop_vlines), .crop_hoff(crop_hoff),
        .crop_hcount(crop_hcount), .done_clr(done_clr), .pix_out_vld(pix_out_vld),
        .line_end(line_end), .frame_end(frame_end), .capture_on(capture_on),
        .frame_done(frame_done)
    );

    int n_checks = 0, n_errors = 0;
    int n_pix, n_line, n_fe, n_bad, fl, fp, fe_line;
    int tl_cur = 255, tp_cur = 255, tl_prev = 255, tp_prev = 255;
    int cyc = 0;

    typedef struct packed {
        logic       crop; logic lsen; logic lsodd;
        logic [7:0] vst; logic [7:0] vln; logic [7:0] hof; logic [7:0] hcn;
        logic [7:0] e_pix; logic [7:0] e_lin; logic [7:0] e_fl; logic [7:0] e_fp;
        logic [7:0] e_fe;
    } vec_t;

    // Frame is 6 lines x 12 pixels; 255 = none / ended at vsync.
    localparam vec_t VECS [8] = '{
        '{1'b0,1'b0,1'b0, 8'd0, 8'd0,8'd0,8'd0, 8'd72,8'd6,8'd0,  8'd0,  8'd255},
        '{1'b0,1'b1,1'b0, 8'd0, 8'd0,8'd0,8'd0, 8'd36,8'd3,8'd0,  8'd0,  8'd255},
        '{1'b0,1'b1,1'b1, 8'd0, 8'd0,8'd0,8'd0, 8'd36,8'd3,8'd1,  8'd0,  8'd255},
        '{1'b1,1'b0,1'b0, 8'd1, 8'd1,8'd2,8'd4, 8'd10,8'd2,8'd1,  8'd2,  8'd2},
        '{1'b1,1'b0,1'b0, 8'd1, 8'd1,8'd0,8'd7, 8'd10,8'd2,8'd1,  8'd0,  8'd2},
        '{1'b1,1'b0,1'b0, 8'd4, 8'd5,8'd8,8'd8, 8'd8, 8'd2,8'd4,  8'd8,  8'd255},
        '{1'b1,1'b1,1'b1, 8'd0, 8'd3,8'd0,8'd0, 8'd2, 8'd2,8'd1,  8'd0,  8'd3},
        '{1'b1,1'b0,1'b0, 8'd10,8'd0,8'd0,8'd0, 8'd0, 8'd0,8'd255,8'd255,8'd255}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_pix = 0; n_line = 0; n_fe = 0; n_bad = 0; fl = 255; fp = 255; fe_line = -1;
    endtask

    // Drive one cycle of inputs just after the clock edge, with a position tag.
    task automatic drive(input logic vs, input logic hs, input logic pv, input int ln, input int px);
        @(posedge clk); #1;
        tl_prev = tl_cur; tp_prev = tp_cur;
        vsync_act = vs; hsync_act = hs; pix_vld = pv; tl_cur = ln; tp_cur = px;
    endtask

    task automatic vblank(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b1, 1'b1, 255, 255);
    endtask
    task automatic hgap(input int l, input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b1, 1'b1, l, 200);
    endtask
    task automatic hline(input int l, input int np);
        for (int p = 0; p < np; p++) drive(1'b0, 1'b0, 1'b1, l, p);
    endtask
    task automatic send_frame(input int nl, input int np);
        vblank(4); hgap(254, 3);
        for (int l = 0; l < nl; l++) begin hline(l, np); hgap(l, 3); end
        vblank(4);
    endtask
    task automatic pulse_set();  cap_set = 1'b1;  vblank(1); cap_set = 1'b0;  vblank(1); endtask
    task automatic pulse_clr();  cap_clr = 1'b1;  vblank(1); cap_clr = 1'b0;  vblank(1); endtask
    task automatic pulse_done(); done_clr = 1'b1; vblank(1); done_clr = 1'b0; vblank(1); endtask

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pix_out_vld) begin
                if (n_pix == 0) begin fl = tl_prev; fp = tp_prev; end
                n_pix++;
                if (tp_prev >= 200) n_bad++;
            end
            if (line_end) n_line++;
            if (frame_end) begin n_fe++; fe_line = tl_prev; end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_checks++; n_errors++;
            $display("FAIL R12 watchdog: actual=%0d expected<%0d cycles", cyc, 150000);
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        clear_counts();
        repeat (3) @(posedge clk);
        #1;
        check("R12 pix_out_vld in reset", int'(pix_out_vld), 0);
        check("R12 line_end in reset",    int'(line_end), 0);
        check("R12 frame_end in reset",   int'(frame_end), 0);
        check("R12 capture_on in reset",  int'(capture_on), 0);
        check("R12 frame_done in reset",  int'(frame_done), 0);
        rst_n = 1'b1;
        vblank(3);

        // Table of snapshot captures: one frame each, then a second unarmed frame.
        for (int i = 0; i < 8; i++) begin
            vec_t v;
            v = VECS[i];
            crop_en = v.crop; line_sel_en = v.lsen; line_sel_odd = v.lsodd;
            crop_vstart = 13'(v.vst); crop_vlines = 14'(v.vln);
            crop_hoff = 14'(v.hof); crop_hcount = 14'(v.hcn);
            snapshot_mode = 1'b1;
            clear_counts();
            pulse_set();
            send_frame(6, 12);
            check($sformatf("R6/R5 vec%0d pixel count", i), n_pix, int'(v.e_pix));
            check($sformatf("R11 vec%0d line_end count", i), n_line, int'(v.e_lin));
            check($sformatf("R6 vec%0d first line", i), fl, int'(v.e_fl));
            check($sformatf("R6/R7 vec%0d first pixel", i), fp, int'(v.e_fp));
            check($sformatf("R11 vec%0d frame_end count", i), n_fe, 1);
            check($sformatf("R8/R9 vec%0d frame_end position", i), fe_line, int'(v.e_fe));
            check($sformatf("R10 vec%0d pixels taken in sync", i), n_bad, 0);
            check($sformatf("R2 vec%0d capture_on auto-cleared", i), int'(capture_on), 0);
            check($sformatf("R13 vec%0d frame_done set", i), int'(frame_done), 1);
            clear_counts();
            send_frame(6, 12);
            check($sformatf("R2 vec%0d no second frame", i), n_pix + n_fe, 0);
            check($sformatf("R13 vec%0d frame_done held", i), int'(frame_done), 1);
            pulse_done();
            check($sformatf("R13 vec%0d frame_done cleared", i), int'(frame_done), 0);
        end

        crop_en = 1'b0; line_sel_en = 1'b0; snapshot_mode = 1'b0;

        // R1: arming mid-frame drops that frame.
        clear_counts();
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, 1'b1, 100, 0);
        cap_set = 1'b1; drive(1'b0, 1'b0, 1'b1, 100, 0); cap_set = 1'b0;
        for (int i = 0; i < 10; i++) drive(1'b0, 1'b0, 1'b1, 100, 0);
        check("R1 no pixel in running frame", n_pix, 0);
        send_frame(2, 4);
        check("R1 next frame captured", n_pix, 8);
        pulse_clr();
        clear_counts();
        send_frame(2, 4);
        check("R1 disarmed between frames", n_pix, 0);

        // R4: frame-rate codes.
        rate_code = 2'b01; clear_counts(); pulse_set();
        for (int f = 0; f < 4; f++) send_frame(2, 4);
        check("R4 code 01 frames kept of 4", n_fe, 2);
        check("R4 code 01 pixels", n_pix, 16);
        pulse_clr(); vblank(2);
        rate_code = 2'b10; clear_counts(); pulse_set();
        for (int f = 0; f < 5; f++) send_frame(2, 4);
        check("R4 code 10 frames kept of 5", n_fe, 2);
        pulse_clr(); vblank(2);
        rate_code = 2'b11; clear_counts(); pulse_set();
        for (int f = 0; f < 2; f++) send_frame(2, 4);
        check("R4 code 11 frames kept of 2", n_fe, 2);
        pulse_clr(); vblank(2);

        // R3: clear during a frame defers the stop to frame end.
        rate_code = 2'b00; clear_counts(); pulse_set();
        vblank(4); hgap(254, 3); hline(0, 4); hgap(0, 1);
        cap_clr = 1'b1; hgap(0, 1); cap_clr = 1'b0; hgap(0, 1);
        check("R3 capture_on drops at once", int'(capture_on), 0);
        hline(1, 4); hgap(1, 3); vblank(4);
        check("R3 frame finished after clear", n_pix, 8);
        check("R3 one frame_end", n_fe, 1);
        clear_counts();
        send_frame(2, 4);
        check("R3 no frame after deferred stop", n_pix + n_fe, 0);

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule